// File: doc/BRIEF.md
# Serial Line Activity Loss Detector

This block watches a small group of serial input lines coming from an external peripheral and decides when that peripheral has stopped driving them, for instance after entering power-down. Logic cannot sense a floating pin, so the board or pad must pull every line to a defined level when it is not driven. The detector infers that the lines are undriven from the absence of edges. Each line is first passed through a synchronizer. Any change on any line restarts an elapsed-time counter. Once the counter reaches a programmable timeout with no further change, the block raises a registered inactive flag.

Two optional qualifiers make false detection less likely. The first requires every line to sit at zero, which suits lines with pull-downs where all-zero is not a normal bus state. The second requires the lines to equal a reserved idle word that the peripheral never sends in normal traffic. When activity returns, the inactive flag drops and a single-cycle wake pulse is raised on the same clock edge.

Top module: `line_quiet_detect`

## Requirements
- R1: Every line passes through a two-flop synchronizer. A line change first sampled at clock edge k leaves both outputs unchanged after edges k and k+1. The change takes effect at edge k+2.
- R2: With both qualifiers off, `quiet` rises after edge k+T+3, where k is the edge that sampled the last line change and T is `timeout`. It is low after edges k+2 through k+T+2. T=0 is allowed.
- R3: While `rst` is high, `quiet` and `wake` are 0. If the lines stay at 0 through reset, `quiet` first reads 1 after the (T+1)-th rising edge following the release of reset, provided the qualifiers allow it.
- R4: The elapsed counter saturates at T and never wraps. While the lines stay steady, `quiet` stays 1 for longer than 2^CNT_W cycles.
- R5: When `quiet` is 1 and a line change reaches the edge detector, `quiet` goes to 0 and `wake` is 1 for exactly one cycle, on the same clock edge. `wake` is 1 only at a 1-to-0 transition of `quiet`.
- R6: With `need_all_low`=1, `quiet` can be 1 only when every synchronized line is 0. A steady non-zero value keeps `quiet` at 0 indefinitely.
- R7: With `need_idle_word`=1, `quiet` can be 1 only when the synchronized lines equal `idle_word` bit for bit. With both qualifiers set, both conditions must hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | N_LINES | Monitored lines, asynchronous to clk, pulled to a defined level when undriven |
| timeout | input | CNT_W | Number of quiet cycles required before the flag is declared |
| need_all_low | input | 1 | When 1, all lines must be 0 to declare inactivity |
| need_idle_word | input | 1 | When 1, the lines must equal idle_word to declare inactivity |
| idle_word | input | N_LINES | Reserved pattern that marks the powered-down state |
| quiet | output | 1 | Registered inactive flag |
| wake | output | 1 | One-cycle pulse when activity resumes after inactivity |

## Verification
Several internal faults can each be seen at the ports, and each shows quickly. A wrong synchronizer depth or a missed edge moves the fall of `quiet` and the `wake` pulse away from the third edge after a change. An off-by-one in the counter or its compare moves the rise of `quiet` by a cycle, and this shows within T+4 cycles. A counter that wraps instead of saturating drops `quiet` without a `wake` pulse about 2^CNT_W cycles into a steady stretch. The bench uses a 4-bit counter so this fault appears within a few dozen cycles. Inverted or ignored qualifiers show up as `quiet` rising on a line value that the selected mode should reject. This appears in the same sweep over all line values.

// File: rtl/lqd_pkg.sv
package lqd_pkg;
  // Selects which confirmations must hold before inactivity is declared.
  typedef struct packed {
    logic all_low;
    logic idle_match;
  } qual_mode_t;
endpackage

// File: rtl/lqd_sync.sv
module lqd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lqd_timer.sv
module lqd_timer #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [CNT_W-1:0] limit,
  output logic             edge_seen,
  output logic             expired,
  output logic [CNT_W-1:0] elapsed
);
  logic [WIDTH-1:0] last_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_seen = |(sync_in ^ last_q);
  assign expired   = (cnt_q >= limit);
  assign elapsed   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else begin
      last_q <= sync_in;
      if (edge_seen)
        cnt_q <= '0;
      else if (cnt_q < limit)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lqd_flag.sv
module lqd_flag
  import lqd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  input  logic             edge_seen,
  input  logic             expired,
  input  qual_mode_t       mode,
  input  logic [WIDTH-1:0] idle_word,
  output logic             quiet,
  output logic             wake
);
  logic low_ok;
  logic word_ok;
  logic qualified;

  assign low_ok    = !mode.all_low    || (sync_in == '0);
  assign word_ok   = !mode.idle_match || (sync_in == idle_word);
  assign qualified = low_ok && word_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet <= 1'b0;
      wake  <= 1'b0;
    end else begin
      quiet <= !edge_seen && expired && qualified;
      wake  <= edge_seen && quiet;
    end
  end
endmodule

// File: rtl/line_quiet_detect.sv
module line_quiet_detect
  import lqd_pkg::*;
#(
  parameter int N_LINES     = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_in,
  input  logic [CNT_W-1:0]   timeout,
  input  logic               need_all_low,
  input  logic               need_idle_word,
  input  logic [N_LINES-1:0] idle_word,
  output logic               quiet,
  output logic               wake
);
  logic [N_LINES-1:0] sync_lines;
  logic               line_edge;
  logic               run_out;
  logic [CNT_W-1:0]   elapsed;
  qual_mode_t         mode;

  assign mode.all_low    = need_all_low;
  assign mode.idle_match = need_idle_word;

  lqd_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lines_in), .sync_out(sync_lines)
  );

  lqd_timer #(.WIDTH(N_LINES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .sync_in(sync_lines), .limit(timeout),
    .edge_seen(line_edge), .expired(run_out), .elapsed(elapsed)
  );

  lqd_flag #(.WIDTH(N_LINES)) u_flag (
    .clk(clk), .rst(rst), .sync_in(sync_lines), .edge_seen(line_edge),
    .expired(run_out), .mode(mode), .idle_word(idle_word),
    .quiet(quiet), .wake(wake)
  );
endmodule

// File: rtl/lqd_checker.sv
module lqd_checker #(
  parameter int N_LINES = 4,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] sync_lines,
  input logic               line_edge,
  input logic [CNT_W-1:0]   elapsed,
  input logic [CNT_W-1:0]   timeout,
  input logic               need_all_low,
  input logic               need_idle_word,
  input logic [N_LINES-1:0] idle_word,
  input logic               quiet,
  input logic               wake
);
  // R2
  rise_after_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(quiet) |-> (!$past(line_edge) && ($past(elapsed) >= $past(timeout))));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ((elapsed == '0) && ($past(elapsed) != '0)) |-> $past(line_edge));

  // R5
  wake_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(quiet) && !quiet));

  // R5
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  // R6
  all_low_qual_chk: assert property (@(posedge clk) disable iff (rst)
    quiet |-> (!$past(need_all_low) || ($past(sync_lines) == '0)));

  // R7
  idle_word_qual_chk: assert property (@(posedge clk) disable iff (rst)
    quiet |-> (!$past(need_idle_word) || ($past(sync_lines) == $past(idle_word))));
endmodule

bind line_quiet_detect lqd_checker #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_lqd_chk (
  .clk(clk), .rst(rst), .sync_lines(sync_lines), .line_edge(line_edge),
  .elapsed(elapsed), .timeout(timeout), .need_all_low(need_all_low),
  .need_idle_word(need_idle_word), .idle_word(idle_word),
  .quiet(quiet), .wake(wake)
);

// File: tb/test_line_quiet_detect.sv
`timescale 1ns/1ps
module test_line_quiet_detect;
  localparam int NL = 4;
  localparam int CW = 4;
  localparam logic [NL-1:0] IDLE = 4'hA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] lines_in = '0;
  logic [CW-1:0] timeout = '0;
  logic          need_all_low = 1'b0;
  logic          need_idle_word = 1'b0;
  logic [NL-1:0] idle_word = IDLE;
  logic          quiet;
  logic          wake;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  line_quiet_detect #(.N_LINES(NL), .CNT_W(CW), .SYNC_STAGES(2)) i_line_quiet_detect (
    .clk(clk), .rst(rst), .lines_in(lines_in), .timeout(timeout),
    .need_all_low(need_all_low), .need_idle_word(need_idle_word),
    .idle_word(idle_word), .quiet(quiet), .wake(wake)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic qual_of(input logic [NL-1:0] v, input int mode);
    logic ok;
    ok = 1'b1;
    if (mode[0] && (v != '0)) ok = 1'b0;
    if (mode[1] && (v != IDLE)) ok = 1'b0;
    return ok;
  endfunction

  function automatic string mode_req(input int mode);
    if (mode[0]) return "R6";
    if (mode[1]) return "R7";
    return "R2";
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int tset [5] = '{0, 1, 2, 5, 15};
    logic prevq;
    logic [NL-1:0] prevv;
    logic [NL-1:0] v;
    logic expq;
    logic expw;
    string req;
    for (int ti = 0; ti < 5; ti++) begin
      for (int mode = 0; mode < 4; mode++) begin
        @(negedge clk);
        rst = 1'b1;
        lines_in = '0;
        timeout = CW'(tset[ti]);
        need_all_low = mode[0];
        need_idle_word = mode[1];
        repeat (3) step();
        chk("R3", "quiet in reset", quiet, 1'b0);
        chk("R3", "wake in reset", wake, 1'b0);
        rst = 1'b0;
        for (int n = 1; n <= tset[ti] + 3; n++) begin
          step();
          chk("R3", "quiet after reset", quiet, (n >= tset[ti] + 1) && qual_of('0, mode));
          chk("R3", "wake after reset", wake, 1'b0);
        end
        prevq = qual_of('0, mode);
        prevv = '0;
        for (int i = 0; i < 16; i++) begin
          v = NL'(i + 1);
          if (v == prevv) v = v ^ 4'h1;
          lines_in = v;
          for (int n = 1; n <= tset[ti] + 24; n++) begin
            step();
            if (n <= 2) begin
              expq = prevq; expw = 1'b0; req = "R1";
            end else if (n == 3) begin
              expq = 1'b0; expw = prevq; req = "R5";
            end else if (n < tset[ti] + 4) begin
              expq = 1'b0; expw = 1'b0; req = "R2";
            end else begin
              expq = qual_of(v, mode); expw = 1'b0;
              req = (n > 18) ? "R4" : mode_req(mode);
            end
            chk(req, "quiet", quiet, expq);
            chk(req, "wake", wake, expw);
          end
          prevq = qual_of(v, mode);
          prevv = v;
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule